// File: doc/BRIEF.md
# Trap and Interrupt Sequencer

This block watches a set of level-sensitive exception request lines (arithmetic overflow, data-type mismatch, page fault, garbage-collection transport, bus error, bus interrupt, local interrupt and call-stack overflow or error). It also watches an internal single-step request. When exceptions are enabled and any of these lines is active, it redirects the machine to the single exception routine at address zero. In that same cycle it drops the commit of the instruction in flight and turns the enable off, so the handler starts with further exceptions masked.

The block holds a small machine control word that software writes through a functional destination. The word has an exception-enable bit, a bit that steers instruction fetch to the boot ROM, and a single-step bit. Reset clears the enable bit and sets the boot bit. Software reads the active requests as a raw, unencoded bit vector; the block applies no priority to it. Alongside each redirection, the block flags how the interrupted instruction must be replayed. Trap-class causes replay it with a handler-supplied destination value. Interrupt-class causes replay it unchanged.

Top module: `trap_sequencer`

## Requirements
- R1: After reset the control word reads enable=0, boot=1, single-step=0, with no redirection and the single-step request bit (pending bit 8) low. The control word's bit 0 is enable, bit 1 is boot and bit 2 is single-step.
- R2: When enable is 1 and any pending bit is set, take_trap_o is high in that same cycle and pc_next_o is zero. Otherwise pc_next_o equals pc_next_i.
- R3: A redirection clears the enable bit on the following clock edge, so take_trap_o lasts exactly one cycle.
- R4: While enable is 0, requests cause no redirection, whatever their pattern.
- R5: pending_o always equals the request lines in bits 7:0 and the single-step request in bit 8, whatever the enable state.
- R6: A control write takes effect on the next edge and reads back on ctl_o, with boot_fetch_o equal to bit 1. A write issued in a redirection cycle is dropped.
- R7: Setting enable while a request is still active redirects in the cycle right after the write.
- R8: A write with both enable and single-step set arms stepping from the next cycle. The instruction committing in the write cycle is not counted. The first later committed, non-squashed instruction raises pending bit 8 one cycle after its commit. That bit stays high until the next accepted control write.
- R9: On a redirection, replay_mod_o is high if pending bit 0 or 1 (overflow or data type) is set. Otherwise replay_exact_o is high. Both are low when there is no redirection.
- R10: commit_o equals commit_i except in a redirection cycle, when it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | 8 | Level exception requests |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 3 | Control word write data |
| commit_i | input | 1 | Current instruction wants to commit |
| pc_next_i | input | 23 | Normal next PC |
| pc_next_o | output | 23 | Next PC after redirection |
| commit_o | output | 1 | Commit after squash |
| take_trap_o | output | 1 | One-cycle redirection pulse |
| replay_mod_o | output | 1 | Replay with modified destination |
| replay_exact_o | output | 1 | Replay exactly |
| pending_o | output | 9 | Raw pending request vector |
| ctl_o | output | 3 | Control word readback |
| boot_fetch_o | output | 1 | Fetch from boot ROM |

## Verification
The assertions check on every cycle that a redirection forces PC zero, never occurs with enable low, lasts one cycle, and clears enable. They also check that the two replay flags never both rise and that a single-step request only appears after a real commit. Only the bench scenarios can show the full mapping from request pattern to replay class across all 256 patterns. The same holds for the exact cycle at which stepping arms and fires, the dropping of a control write in a redirection cycle, and the immediate re-trap when enable is set over an active request.

// File: rtl/trapseq_pkg.sv
package trapseq_pkg;
  localparam int CTL_W   = 3;
  localparam int CTL_EN  = 0;
  localparam int CTL_BOOT = 1;
  localparam int CTL_STEP = 2;

  typedef struct packed {
    logic step;
    logic boot;
    logic en;
  } ctl_t;

  function automatic ctl_t ctl_reset_value();
    ctl_t c;
    c.step = 1'b0;
    c.boot = 1'b1;
    c.en   = 1'b0;
    return c;
  endfunction

  function automatic ctl_t ctl_after_trap(input ctl_t c);
    ctl_t r;
    r = c;
    r.en = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/trap_ctl_reg.sv
module trap_ctl_reg
  import trapseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  ctl_t wdata_i,
  input  logic take_trap_i,
  output logic wr_accept_o,
  output ctl_t ctl_q
);
  assign wr_accept_o = wr_i & ~take_trap_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ctl_q <= ctl_reset_value();
    else if (take_trap_i) ctl_q <= ctl_after_trap(ctl_q);
    else if (wr_i)        ctl_q <= wdata_i;
  end

  p_self_disable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap_i |=> !ctl_q.en);
  p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept_o |=> ctl_q == $past(wdata_i));
endmodule

// File: rtl/trap_sstep.sv
module trap_sstep (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_accept_i,
  input  logic wr_en_i,
  input  logic wr_step_i,
  input  logic commit_i,
  input  logic take_trap_i,
  output logic step_req_o
);
  logic armed_q;
  logic step_fire;

  assign step_fire = armed_q & commit_i & ~take_trap_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      step_req_o <= 1'b0;
    end else if (wr_accept_i) begin
      armed_q    <= wr_en_i & wr_step_i;
      step_req_o <= 1'b0;
    end else if (step_fire) begin
      armed_q    <= 1'b0;
      step_req_o <= 1'b1;
    end
  end

  p_fire_after_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_req_o) |-> $past(commit_i && !take_trap_i));
  p_single_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(armed_q && step_req_o));
endmodule

// File: rtl/trap_decide.sv
module trap_decide #(
  parameter int N_PEND = 9,
  parameter int PC_W = 23,
  parameter logic [N_PEND-1:0] TRAP_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PEND-1:0] pend_i,
  input  logic              en_i,
  input  logic              commit_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic              take_o,
  output logic              commit_o,
  output logic [PC_W-1:0]   pc_o,
  output logic              mod_o,
  output logic              exact_o
);
  function automatic logic any_trap_class(input logic [N_PEND-1:0] p);
    return |(p & TRAP_MASK);
  endfunction

  function automatic logic [PC_W-1:0] pick_pc(input logic take, input logic [PC_W-1:0] pc);
    return take ? '0 : pc;
  endfunction

  logic cls_trap;

  assign take_o   = en_i & (|pend_i);
  assign cls_trap = any_trap_class(pend_i);
  assign pc_o     = pick_pc(take_o, pc_i);
  assign commit_o = commit_i & ~take_o;
  assign mod_o    = take_o & cls_trap;
  assign exact_o  = take_o & ~cls_trap;

  p_pc_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> pc_o == '0);
  p_quiet_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !take_o && pc_o == pc_i);
  p_one_class_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $onehot({mod_o, exact_o}));
  p_no_class_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> !mod_o && !exact_o);
  p_squash_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !commit_o);
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trapseq_pkg::*;
#(
  parameter int N_REQ = 8,
  parameter int PC_W = 23,
  parameter logic [N_REQ:0] TRAP_MASK = 9'h003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_REQ-1:0]  req_i,
  input  logic              ctl_wr_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  input  logic              commit_i,
  input  logic [PC_W-1:0]   pc_next_i,
  output logic [PC_W-1:0]   pc_next_o,
  output logic              commit_o,
  output logic              take_trap_o,
  output logic              replay_mod_o,
  output logic              replay_exact_o,
  output logic [N_REQ:0]    pending_o,
  output logic [CTL_W-1:0]  ctl_o,
  output logic              boot_fetch_o
);
  localparam int N_PEND = N_REQ + 1;

  ctl_t ctl_q;
  ctl_t wdata;
  logic wr_accept;
  logic step_req;
  logic take;

  assign wdata = ctl_t'(ctl_wdata_i);
  assign pending_o = {step_req, req_i};

  trap_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_i(ctl_wr_i), .wdata_i(wdata),
    .take_trap_i(take), .wr_accept_o(wr_accept), .ctl_q(ctl_q)
  );

  trap_sstep u_step (
    .clk(clk), .rst_n(rst_n), .wr_accept_i(wr_accept),
    .wr_en_i(wdata.en), .wr_step_i(wdata.step), .commit_i(commit_i),
    .take_trap_i(take), .step_req_o(step_req)
  );

  trap_decide #(.N_PEND(N_PEND), .PC_W(PC_W), .TRAP_MASK(TRAP_MASK)) u_dec (
    .clk(clk), .rst_n(rst_n), .pend_i(pending_o), .en_i(ctl_q.en),
    .commit_i(commit_i), .pc_i(pc_next_i), .take_o(take), .commit_o(commit_o),
    .pc_o(pc_next_o), .mod_o(replay_mod_o), .exact_o(replay_exact_o)
  );

  assign take_trap_o  = take;
  assign ctl_o        = ctl_q;
  assign boot_fetch_o = ctl_q.boot;

  p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap_o |=> !take_trap_o);
  p_raw_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pending_o[N_REQ-1:0] == req_i);
endmodule

// File: tb/tb_trap_sequencer.sv
module tb_trap_sequencer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] req_i = '0;
  logic ctl_wr_i = 1'b0;
  logic [2:0] ctl_wdata_i = '0;
  logic commit_i = 1'b0;
  logic [22:0] pc_next_i = '0;
  logic [22:0] pc_next_o;
  logic commit_o, take_trap_o, replay_mod_o, replay_exact_o, boot_fetch_o;
  logic [8:0] pending_o;
  logic [2:0] ctl_o;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  trap_sequencer dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ctl_wr_i(ctl_wr_i),
    .ctl_wdata_i(ctl_wdata_i), .commit_i(commit_i), .pc_next_i(pc_next_i),
    .pc_next_o(pc_next_o), .commit_o(commit_o), .take_trap_o(take_trap_o),
    .replay_mod_o(replay_mod_o), .replay_exact_o(replay_exact_o),
    .pending_o(pending_o), .ctl_o(ctl_o), .boot_fetch_o(boot_fetch_o)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    #2;
  endtask

  task automatic wr_ctl(input logic [2:0] v);
    ctl_wr_i = 1'b1; ctl_wdata_i = v;
    cyc();
    ctl_wr_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic exp_take;
    logic exp_mod;
    logic [22:0] pc;
    repeat (2) @(negedge clk);
    #2;
    // R1 reset state
    chk(ctl_o == 3'b010, "R1 ctl", ctl_o, 3'b010);
    chk(boot_fetch_o == 1'b1, "R1 boot", boot_fetch_o, 1);
    chk(take_trap_o == 1'b0, "R1 take", take_trap_o, 0);
    chk(pending_o == 9'h0, "R1 pending", pending_o, 0);
    rst_n = 1'b1;
    cyc();
    chk(ctl_o == 3'b010, "R1 ctl after release", ctl_o, 3'b010);

    // Sweep all request patterns with enable off and on (R2 R3 R4 R5 R9 R10)
    for (int en = 0; en < 2; en++) begin
      for (int p = 0; p < 256; p++) begin
        req_i = '0;
        wr_ctl({1'b0, 1'b1, en[0]});
        chk(ctl_o == {1'b0, 1'b1, en[0]}, "R6 readback", ctl_o, {1'b0, 1'b1, en[0]});
        pc = 23'(p * 7 + 5);
        req_i = p[7:0]; pc_next_i = pc; commit_i = 1'b1;
        #1;
        exp_take = (en == 1) && (p != 0);
        exp_mod  = exp_take && (p[1:0] != 2'b00);
        if (en == 0) chk(take_trap_o == 1'b0, "R4 no trap when disabled", take_trap_o, 0);
        chk(take_trap_o == exp_take, "R2 take", take_trap_o, exp_take);
        chk(pc_next_o == (exp_take ? 23'd0 : pc), "R2 pc", pc_next_o, exp_take ? 23'd0 : pc);
        chk(pending_o == {1'b0, p[7:0]}, "R5 raw pending", pending_o, {1'b0, p[7:0]});
        chk(replay_mod_o == exp_mod, "R9 mod", replay_mod_o, exp_mod);
        chk(replay_exact_o == (exp_take && !exp_mod), "R9 exact", replay_exact_o, exp_take && !exp_mod);
        chk(commit_o == !exp_take, "R10 commit", commit_o, !exp_take);
        cyc();
        commit_i = 1'b0;
        if (exp_take) begin
          chk(ctl_o[0] == 1'b0, "R3 enable cleared", ctl_o, 0);
          chk(take_trap_o == 1'b0, "R3 pulse one cycle", take_trap_o, 0);
        end
        req_i = '0;
      end
    end

    // R7 re-enable over an active request
    req_i = 8'h20;
    wr_ctl(3'b000);
    ctl_wr_i = 1'b1; ctl_wdata_i = 3'b011;
    #1;
    chk(take_trap_o == 1'b0, "R7 no trap in write cycle", take_trap_o, 0);
    cyc();
    ctl_wr_i = 1'b0;
    chk(take_trap_o == 1'b1, "R7 trap right after write", take_trap_o, 1);
    chk(pc_next_o == 23'd0, "R7 pc zero", pc_next_o, 0);

    // R6 write dropped during a redirection cycle
    ctl_wr_i = 1'b1; ctl_wdata_i = 3'b101;
    cyc();
    ctl_wr_i = 1'b0;
    chk(ctl_o == 3'b010, "R6 write dropped in trap cycle", ctl_o, 3'b010);
    chk(boot_fetch_o == 1'b1, "R6 boot", boot_fetch_o, 1);
    req_i = '0;
    wr_ctl(3'b000);
    chk(boot_fetch_o == 1'b0, "R6 boot cleared", boot_fetch_o, 0);

    // R8 single step
    commit_i = 1'b1;
    wr_ctl(3'b101);
    commit_i = 1'b0;
    chk(pending_o[8] == 1'b0, "R8 write-cycle commit not counted", pending_o[8], 0);
    cyc();
    chk(pending_o[8] == 1'b0, "R8 idle without commit", pending_o[8], 0);
    commit_i = 1'b1;
    #1;
    chk(take_trap_o == 1'b0, "R8 no trap on stepped commit", take_trap_o, 0);
    cyc();
    commit_i = 1'b0;
    chk(pending_o[8] == 1'b1, "R8 step request raised", pending_o[8], 1);
    chk(take_trap_o == 1'b1, "R8 step trap", take_trap_o, 1);
    chk(replay_exact_o == 1'b1, "R9 step is exact replay", replay_exact_o, 1);
    cyc();
    chk(take_trap_o == 1'b0, "R3 step trap one cycle", take_trap_o, 0);
    chk(pending_o[8] == 1'b1, "R8 step request held", pending_o[8], 1);
    commit_i = 1'b1;
    cyc();
    commit_i = 1'b0;
    chk(pending_o[8] == 1'b1, "R8 held until write", pending_o[8], 1);
    wr_ctl(3'b000);
    chk(pending_o[8] == 1'b0, "R8 cleared by write", pending_o[8], 0);

    // R8 squashed commit does not count
    req_i = 8'h04;
    wr_ctl(3'b101);
    commit_i = 1'b1;
    #1;
    chk(take_trap_o == 1'b1, "R8 trap squashes", take_trap_o, 1);
    cyc();
    commit_i = 1'b0;
    chk(pending_o[8] == 1'b0, "R8 squashed commit ignored", pending_o[8], 0);
    req_i = '0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule